// File: doc/BRIEF.md
# Serial PCM Word Transmitter

This block sends one 8-bit companded sample per frame through a serial data pin that can be released to high impedance. A word is written into a holding buffer with a load strobe. When the next accepted frame sync pulse arrives, that word is shifted out sign bit first, one bit per rising edge of the external bit clock. If no new word was loaded in the meantime, the same word is sent again.

Frame sync pulses come in two shapes. A short pulse lasts one bit period, and a long pulse lasts two or more. The block measures each accepted pulse and keeps the result in a mode flag. The flag that is current when a frame begins decides when the output enable rises and falls during that frame. Both the bit clock and the frame sync are oversampled by a faster system clock, which must run at four or more times the bit clock. All decisions are made on edges found in that domain.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, the output enable is low and the mode flag reads 0 (short).
- R2: When an accepted frame sync pulse falls, the mode flag becomes 1 if the pulse was high across two or more falling bit clock edges, and 0 if it was high across one.
- R3: With the flag at 0, a frame sync that is high at a falling bit clock edge makes the next rising bit clock edge raise the output enable and drive the sign bit.
- R4: With the flag at 0, the seven rising edges after the sign bit shift out the other seven bits, and the falling edge after the eighth rising edge lowers the enable.
- R5: With the flag at 1, the enable rises at whichever comes later: the frame sync rising edge or a bit clock rising edge. If the frame sync rises while the bit clock is high, the enable rises at once. The sign bit is driven first.
- R6: With the flag at 1, the remaining seven bits go out on the next seven rising edges. The enable falls at whichever comes later: the falling edge after the eighth rising edge, or the frame sync going low.
- R7: Bits leave most significant bit first. The word sent is the last one loaded before the frame starts, and a frame with no load in between repeats the previous word.
- R8: A frame sync pulse that arrives while a word is being sent is ignored: it neither starts a frame nor changes the mode flag. A load during a frame changes only the next frame.
- R9: A frame uses the mode flag held at its start, so the first frame after a change of pulse length still follows the previous timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Writes code_i into the holding buffer |
| code_i | input | 8 | Companded word to send |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External transmit frame sync |
| dout_o | output | 1 | Serial data, valid while dout_oe_o is high |
| dout_oe_o | output | 1 | Tri-state enable for the data pin |
| long_mode_o | output | 1 | Measured pulse mode, 1 for long |

## Verification
The assertions assume that the bit clock holds each level for at least two system clock cycles. They also assume that the frame sync changes only at a rising bit clock edge, or during the high phase, and never at a falling edge. The bench drives every bit period as eight high and eight low system cycles. It changes the frame sync either exactly at the rising edge or two cycles into the high phase. Pulse lengths, words and these offsets are chosen at random from a fixed seed. Directed frames cover mode changes, repeated words, loads during a frame and stray pulses during a frame.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SHIFT = 2'd2,
    TX_TAIL  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pcm_tx_mode.sv
module pcm_tx_mode #(
  parameter int LONG_MIN = 2,
  localparam int CW      = $clog2(LONG_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic fs_lvl,
  input  logic fs_fall,
  input  logic bclk_fall,
  output logic long_mode
);
  logic          meas_q, meas_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          long_q, long_n;

  always_comb begin
    meas_n = meas_q;
    cnt_n  = cnt_q;
    long_n = long_q;
    if (accept) begin
      meas_n = 1'b1;
      cnt_n  = '0;
    end else if (meas_q) begin
      if (fs_lvl && bclk_fall && (cnt_q != CW'(LONG_MIN)))
        cnt_n = cnt_q + 1'b1;
      if (fs_fall) begin
        meas_n = 1'b0;
        long_n = (cnt_q >= CW'(LONG_MIN));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= 1'b0;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      meas_q <= meas_n;
      cnt_q  <= cnt_n;
      long_q <= long_n;
    end
  end

  assign long_mode = long_q;

  // R2
  mode_on_fs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_q) |-> $past(fs_fall));
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_tx_pkg::*;
#(
  parameter int W   = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] code,
  input  logic         long_mode,
  input  logic         bclk_lvl,
  input  logic         bclk_rise,
  input  logic         bclk_fall,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic         fs_fall,
  output logic         idle,
  output logic         dout,
  output logic         oe
);
  tx_state_e     st_q, st_n;
  logic [W-1:0]  buf_q, buf_n;
  logic [W-1:0]  sreg_q, sreg_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          oe_q, oe_n;
  logic          fresh_q, fresh_n;
  logic          fseen_q, fseen_n;
  logic          fl_q, fl_n;
  logic          start;

  always_comb begin
    st_n    = st_q;
    buf_n   = load ? code : buf_q;
    sreg_n  = sreg_q;
    cnt_n   = cnt_q;
    oe_n    = oe_q;
    fresh_n = fresh_q;
    fseen_n = fseen_q;
    fl_n    = fl_q;
    start   = 1'b0;

    if (fs_rise && st_q == TX_IDLE) fresh_n = 1'b1;
    if (fs_fall)                    fresh_n = 1'b0;

    case (st_q)
      TX_IDLE: begin
        fl_n = long_mode;
        if (long_mode) begin
          if (fs_rise) begin
            fresh_n = 1'b0;
            if (bclk_lvl) start = 1'b1;
            else          st_n  = TX_ARMED;
          end
        end else if (bclk_fall && fs_lvl && fresh_q) begin
          fresh_n = 1'b0;
          st_n    = TX_ARMED;
        end
      end
      TX_ARMED: begin
        if (bclk_rise) start = 1'b1;
      end
      TX_SHIFT: begin
        if (bclk_rise) begin
          sreg_n = {sreg_q[W-2:0], 1'b0};
          cnt_n  = cnt_q + 1'b1;
          if (cnt_q == CW'(W - 1)) begin
            st_n    = TX_TAIL;
            fseen_n = 1'b0;
          end
        end
      end
      TX_TAIL: begin
        if (fl_q) begin
          fseen_n = fseen_q | bclk_fall;
          if ((fseen_q || bclk_fall) && !fs_lvl) begin
            st_n = TX_IDLE;
            oe_n = 1'b0;
          end
        end else if (bclk_fall) begin
          st_n = TX_IDLE;
          oe_n = 1'b0;
        end
      end
      default: st_n = TX_IDLE;
    endcase

    if (start) begin
      st_n   = TX_SHIFT;
      sreg_n = buf_q;
      cnt_n  = CW'(1);
      oe_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      buf_q   <= '0;
      sreg_q  <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      fresh_q <= 1'b0;
      fseen_q <= 1'b0;
      fl_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      buf_q   <= buf_n;
      sreg_q  <= sreg_n;
      cnt_q   <= cnt_n;
      oe_q    <= oe_n;
      fresh_q <= fresh_n;
      fseen_q <= fseen_n;
      fl_q    <= fl_n;
    end
  end

  assign idle = (st_q == TX_IDLE);
  assign dout = sreg_q[W-1];
  assign oe   = oe_q;

  // R3 R5
  oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(bclk_rise || fs_rise));
  // R4 R6
  oe_off_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(bclk_fall || fs_fall));
  // R4 R6
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
  // R8
  busy_keeps_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_SHIFT) |=> oe_q);
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int WORD_W   = 8,
  parameter int SYNC_STG = 2,
  parameter int LONG_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] code_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              long_mode_o
);
  localparam int BIT_BCLK = 0;
  localparam int BIT_FS   = 1;

  logic [1:0] lvl, rise, fall;
  logic       idle, long_mode;

  pcm_tx_sync #(.W(2), .STAGES(SYNC_STG)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({fsync_i, bclk_i}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  pcm_tx_mode #(.LONG_MIN(LONG_MIN)) mode_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (rise[BIT_FS] & idle),
    .fs_lvl   (lvl[BIT_FS]),
    .fs_fall  (fall[BIT_FS]),
    .bclk_fall(fall[BIT_BCLK]),
    .long_mode(long_mode)
  );

  pcm_tx_shift #(.W(WORD_W)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_i),
    .code     (code_i),
    .long_mode(long_mode),
    .bclk_lvl (lvl[BIT_BCLK]),
    .bclk_rise(rise[BIT_BCLK]),
    .bclk_fall(fall[BIT_BCLK]),
    .fs_lvl   (lvl[BIT_FS]),
    .fs_rise  (rise[BIT_FS]),
    .fs_fall  (fall[BIT_FS]),
    .idle     (idle),
    .dout     (dout_o),
    .oe       (dout_oe_o)
  );

  assign long_mode_o = long_mode;
endmodule

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] code = 8'h00;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic       dout, oe, lmode;

  int  n_chk = 0;
  int  n_err = 0;
  bit  exp_long = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  pcm_tx_port dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(code),
    .bclk_i(bclk), .fsync_i(fsync),
    .dout_o(dout), .dout_oe_o(oe), .long_mode_o(lmode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] w);
    @(negedge clk); load = 1'b1; code = w;
    @(negedge clk); load = 1'b0;
  endtask

  // one bit period: 8 cycles high, 8 low; fs changes at the rise or 2 cycles later
  task automatic period(input bit fs_val, input bit early,
                        output bit hi_oe, output bit hi_d, output bit lo_oe);
    @(negedge clk); bclk = 1'b1; if (!early) fsync = fs_val;
    repeat (2) @(negedge clk);
    if (early) fsync = fs_val;
    repeat (5) @(negedge clk);
    hi_oe = oe; hi_d = dout;
    @(negedge clk); bclk = 1'b0;
    repeat (7) @(negedge clk);
    lo_oe = oe;
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic frame(input logic [7:0] word, input int len, input bit early,
                       input int extra_p, input bit mid_load,
                       input logic [7:0] mid_word, input string tag);
    int  n;
    bit  ho, hd, lo;
    bit  e_ho, e_lo;
    int  idx;
    string t_on, t_off;
    n = imax(9, len) + 2;
    t_on  = exp_long ? "R5" : "R3";
    t_off = exp_long ? "R6" : "R4";
    if (tag != "") begin t_on = tag; t_off = tag; end
    for (int p = 0; p < n; p++) begin
      period((p < len) || (extra_p != 0 && p == extra_p), early, ho, hd, lo);
      if (exp_long) begin
        e_ho = (p < imax(8, len));
        e_lo = (p < imax(7, len));
        idx  = p;
      end else begin
        e_ho = (p >= 1 && p <= 8);
        e_lo = (p >= 1 && p <= 7);
        idx  = p - 1;
      end
      chk(ho == e_ho, t_on, $sformatf("oe high phase p=%0d", p), ho, e_ho);
      chk(lo == e_lo, t_off, $sformatf("oe low phase p=%0d", p), lo, e_lo);
      if (idx >= 0 && idx < 8)
        chk(hd == word[7-idx], (tag != "") ? tag : "R7",
            $sformatf("bit %0d", idx), hd, word[7-idx]);
      if (mid_load && p == 3) do_load(mid_word);
    end
    exp_long = (len >= 2);
    chk(lmode == exp_long, (tag != "") ? tag : "R2", "mode flag", lmode, exp_long);
  endtask

  initial begin
    logic [7:0] w, w2;
    int         l;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(oe == 1'b0, "R1", "oe after reset", oe, 0);
    chk(lmode == 1'b0, "R1", "mode after reset", lmode, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(oe == 1'b0, "R1", "oe idle", oe, 0);

    do_load(8'hA5);
    frame(8'hA5, 1, 1'b0, 0, 1'b0, 8'h00, "");
    // R7 resend without load
    frame(8'hA5, 1, 1'b0, 0, 1'b0, 8'h00, "");
    do_load(8'h3C);
    // R9 long pulse while flag short: short timing this frame
    frame(8'h3C, 3, 1'b0, 0, 1'b0, 8'h00, "R9");
    do_load(8'hC3);
    frame(8'hC3, 3, 1'b0, 0, 1'b0, 8'h00, "");
    do_load(8'h81);
    frame(8'h81, 10, 1'b0, 0, 1'b0, 8'h00, "");
    do_load(8'h7E);
    frame(8'h7E, 8, 1'b1, 0, 1'b0, 8'h00, "");
    do_load(8'h5A);
    frame(8'h5A, 2, 1'b1, 0, 1'b0, 8'h00, "");
    do_load(8'h0F);
    // R8 stray pulse during long frame is ignored, flag unchanged
    frame(8'h0F, 3, 1'b0, 4, 1'b0, 8'h00, "R8");
    do_load(8'hF0);
    frame(8'hF0, 1, 1'b0, 0, 1'b0, 8'h00, "");
    do_load(8'h96);
    // R8 stray pulse and load during a short frame
    frame(8'h96, 1, 1'b0, 4, 1'b1, 8'h69, "R8");
    frame(8'h69, 1, 1'b0, 0, 1'b0, 8'h00, "R8");

    for (int k = 0; k < 30; k++) begin
      w  = 8'($urandom);
      l  = 1 + int'($urandom % 10);
      do_load(w);
      frame(w, l, 1'($urandom), 0, 1'b0, 8'h00, "");
    end
    w2 = 8'h00;
    frame(w, 1, 1'b0, 0, 1'b0, w2, "");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule